// File: doc/BRIEF.md
# Timer Channel with Capture, Compare and PWM

This block is one channel of a general-purpose timer. It has its own 16-bit up counter with a programmable terminal count. The counter either wraps to zero after the terminal count or, in center-aligned operation, reverses there and counts back down to zero. One 16-bit channel value register does two jobs. In capture operation it records the counter when a selected edge arrives on the input pin. In the other functions it holds the threshold that drives the channel output.

Three configuration inputs pick the function: a center-align select, a two-bit mode field and a two-bit edge/level field. Software reaches the channel value and the status flag over an 8-bit byte bus. Byte-wise access keeps 16-bit values coherent in both directions. Reads are frozen across a capture, and writes are staged until both halves have arrived. A channel flag marks each capture or match and can raise an interrupt request.

Top module: `cappwm_chan`

## Requirements
- R1: While reset is asserted and just after it, the counter reads 0, the channel value reads 0, the output is low, the flag reads 0 and the interrupt request is low.
- R2: With center select 0 the counter steps up by one each clock and goes to 0 on the clock after it reaches (or exceeds) the modulus. With center select 1 it counts up to the modulus, then down to 0, then up again, changing by one each clock.
- R3: In capture mode (center 0, mode 00), edge field 01 captures only on a rising pin edge, 10 only on a falling edge, and 11 on both. An edge of the unselected kind leaves the channel value unchanged.
- R4: The pin passes through a two-stage synchronizer. Counting from the first clock edge after the pin changes, the channel value takes the counter value that was present between the second and third clock edges, and it does so at the third edge.
- R5: In compare mode (center 0, mode 01), on the clock after the counter equals the channel value, the output toggles for edge field 01, goes low for 10 and goes high for 11.
- R6: In edge-aligned PWM (center 0, mode 1x), the output equals (counter < value) for edge field 10 and its inverse for edge fields 01 and 11. A value of 0 gives a constant low high-true output, and a value above the modulus gives a constant high one.
- R7: With center select 1 the mode bits have no effect: the counter runs up and down and the output follows the same level rule as R6 in both directions.
- R8: Edge field 00 holds the output low in every function and blocks all captures and the capture flag.
- R9: Byte select 1 is the value's high byte and 2 is its low byte. In capture mode, reading one byte freezes the pair. The other byte then returns the frozen half even if a capture happened in between, and reading it releases the freeze.
- R10: In compare and PWM functions, a write to one value byte has no effect until the other byte is written, and then both halves take effect together. Value writes in capture mode are ignored.
- R11: Any access to the status location (byte select 0) discards a half-finished write and releases a frozen read.
- R12: The flag is bit 7 of the status byte. It sets on a capture, or on a counter/value match in the other functions. A status read that sees it set, followed by a status write with bit 7 = 0, clears it. A zero write without that read leaves it set. The interrupt request is the flag gated by the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modulus | input | 16 | Counter terminal count |
| center_sel | input | 1 | 1 selects up/down counting and center-aligned PWM |
| mode_sel | input | 2 | Function field: 00 capture, 01 compare, 1x edge PWM |
| edge_sel | input | 2 | Edge or output-action field; 00 disconnects the pin |
| irq_en | input | 1 | Interrupt enable for the channel flag |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_sel | input | 2 | 0 status, 1 value high byte, 2 value low byte |
| bus_rd | input | 1 | Read strobe, one clock |
| bus_wr | input | 1 | Write strobe, one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| ch_out | output | 1 | Channel output |
| irq | output | 1 | Interrupt request |
| cnt_val | output | 16 | Current counter value |

## Verification
The hardest case to reach is a capture that lands between the two byte reads of the channel value. The capture has to be timed through the synchronizer so that it fires after the first read has frozen the pair and before the second read. The stimulus reads the high byte, then toggles the pin and waits the synchronizer latency before reading the low byte. It repeats the sequence with a status access in the gap to show that the freeze is released. The expected capture values come from the counter as observed at the port in the detection cycle.

// File: rtl/cappwm_pkg.sv
package cappwm_pkg;

   typedef enum logic [1:0] {
      FN_CAPTURE    = 2'd0,
      FN_COMPARE    = 2'd1,
      FN_EDGE_PWM   = 2'd2,
      FN_CENTER_PWM = 2'd3
   } chan_fn_e;

   localparam logic [1:0] SEL_STAT = 2'd0;
   localparam logic [1:0] SEL_HI   = 2'd1;
   localparam logic [1:0] SEL_LO   = 2'd2;

   function automatic chan_fn_e decode_fn(input logic center, input logic [1:0] mode);
      chan_fn_e f;
      if (center)               f = FN_CENTER_PWM;
      else if (mode == 2'b00)   f = FN_CAPTURE;
      else if (mode == 2'b01)   f = FN_COMPARE;
      else                      f = FN_EDGE_PWM;
      return f;
   endfunction

endpackage

// File: rtl/cappwm_counter.sv
module cappwm_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          center,
   input  logic [CW-1:0] modulus,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_d
);

   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] ZERO = '0;

   logic up_q, up_d;

   always_comb begin
      cnt_d = cnt_q;
      up_d  = up_q;
      if (!center) begin
         up_d  = 1'b1;
         cnt_d = (cnt_q >= modulus) ? ZERO : cnt_q + ONE;
      end else if (up_q) begin
         if (cnt_q >= modulus) begin
            up_d  = (modulus == ZERO);
            cnt_d = (modulus == ZERO) ? ZERO : modulus - ONE;
         end else begin
            cnt_d = cnt_q + ONE;
         end
      end else begin
         if (cnt_q == ZERO) begin
            up_d  = 1'b1;
            cnt_d = (modulus == ZERO) ? ZERO : ONE;
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         up_q  <= up_d;
      end
   end

endmodule

// File: rtl/cappwm_edge_sync.sv
module cappwm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] edge_sel,
   output logic       edge_evt
);

   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("cappwm_edge_sync: STAGES must be at least 2");
   end

   logic [LAST:0] sh_q;

   for (genvar i = 0; i <= LAST; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sh_q[i] <= 1'b0;
         else if (i == 0) sh_q[i] <= pin;
         else             sh_q[i] <= sh_q[(i == 0) ? 0 : i-1];
      end
   end

   logic cur, prev;
   assign cur  = sh_q[LAST-1];
   assign prev = sh_q[LAST];

   always_comb begin
      unique case (edge_sel)
         2'b01:   edge_evt = cur & ~prev;
         2'b10:   edge_evt = ~cur & prev;
         2'b11:   edge_evt = cur ^ prev;
         default: edge_evt = 1'b0;
      endcase
   end

endmodule

// File: rtl/cappwm_valreg.sv
module cappwm_valreg
   import cappwm_pkg::*;
#(
   parameter int BW = 8,
   localparam int CW = 2 * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_mode,
   input  logic          cap_evt,
   input  logic [CW-1:0] cap_val,
   input  logic [1:0]    sel,
   input  logic          rd,
   input  logic          wr,
   input  logic [BW-1:0] wdata,
   input  logic          stat_acc,
   output logic [CW-1:0] cval,
   output logic [BW-1:0] val_rdata
);

   logic [CW-1:0] cval_q, rbuf_q;
   logic          rlat_q, rlat_hi_q;
   logic [BW-1:0] whold_q;
   logic          wpend_q, wpend_hi_q;

   logic is_hi, hit, rd_hit, wr_hit;
   assign is_hi  = (sel == SEL_HI);
   assign hit    = is_hi || (sel == SEL_LO);
   assign rd_hit = rd && hit;
   assign wr_hit = wr && hit;

   logic [CW-1:0] src;
   assign src       = rlat_q ? rbuf_q : cval_q;
   assign val_rdata = is_hi ? src[CW-1:BW] : src[BW-1:0];
   assign cval      = cval_q;

   // read-side freeze, active only while capturing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rlat_q    <= 1'b0;
         rlat_hi_q <= 1'b0;
         rbuf_q    <= '0;
      end else if (stat_acc || !cap_mode) begin
         rlat_q <= 1'b0;
      end else if (rd_hit) begin
         if (!rlat_q) begin
            rlat_q    <= 1'b1;
            rlat_hi_q <= is_hi;
            rbuf_q    <= cval_q;
         end else if (is_hi != rlat_hi_q) begin
            rlat_q <= 1'b0;
         end
      end
   end

   // write staging and the value register itself
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cval_q     <= '0;
         whold_q    <= '0;
         wpend_q    <= 1'b0;
         wpend_hi_q <= 1'b0;
      end else if (cap_mode) begin
         wpend_q <= 1'b0;
         if (cap_evt) cval_q <= cap_val;
      end else if (stat_acc) begin
         wpend_q <= 1'b0;
      end else if (wr_hit) begin
         if (wpend_q && (wpend_hi_q != is_hi)) begin
            cval_q  <= is_hi ? {wdata, whold_q} : {whold_q, wdata};
            wpend_q <= 1'b0;
         end else begin
            whold_q    <= wdata;
            wpend_q    <= 1'b1;
            wpend_hi_q <= is_hi;
         end
      end
   end

endmodule

// File: rtl/cappwm_chan.sv
module cappwm_chan
   import cappwm_pkg::*;
#(
   parameter int BW          = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CW         = 2 * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] modulus,
   input  logic          center_sel,
   input  logic [1:0]    mode_sel,
   input  logic [1:0]    edge_sel,
   input  logic          irq_en,
   input  logic          cap_pin,
   input  logic [1:0]    bus_sel,
   input  logic          bus_rd,
   input  logic          bus_wr,
   input  logic [BW-1:0] bus_wdata,
   output logic [BW-1:0] bus_rdata,
   output logic          ch_out,
   output logic          irq,
   output logic [CW-1:0] cnt_val
);

   if (BW < 2) begin : g_bad_bw
      $error("cappwm_chan: BW must be at least 2");
   end

   chan_fn_e      fn;
   logic          cap_mode, edge_evt, cap_evt, match;
   logic [CW-1:0] cnt_q, cnt_d, cval;
   logic [BW-1:0] val_rdata;
   logic          stat_rd, stat_wr, stat_acc;
   logic          flag, arm_q, out_q;

   assign fn       = decode_fn(center_sel, mode_sel);
   assign cap_mode = (fn == FN_CAPTURE);
   assign stat_rd  = bus_rd && (bus_sel == SEL_STAT);
   assign stat_wr  = bus_wr && (bus_sel == SEL_STAT);
   assign stat_acc = stat_rd || stat_wr;

   cappwm_counter #(.CW(CW)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .center  (center_sel),
      .modulus (modulus),
      .cnt_q   (cnt_q),
      .cnt_d   (cnt_d)
   );

   cappwm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_pin),
      .edge_sel (edge_sel),
      .edge_evt (edge_evt)
   );

   assign cap_evt = cap_mode && edge_evt;
   assign match   = !cap_mode && (cnt_q == cval);

   cappwm_valreg #(.BW(BW)) val_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_mode  (cap_mode),
      .cap_evt   (cap_evt),
      .cap_val   (cnt_q),
      .sel       (bus_sel),
      .rd        (bus_rd),
      .wr        (bus_wr),
      .wdata     (bus_wdata),
      .stat_acc  (stat_acc),
      .cval      (cval),
      .val_rdata (val_rdata)
   );

   // channel flag with read-then-write-zero clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (stat_wr)               arm_q <= 1'b0;
         else if (stat_rd && flag)  arm_q <= 1'b1;
         if (cap_evt || match)
            flag <= 1'b1;
         else if (stat_wr && arm_q && !bus_wdata[BW-1])
            flag <= 1'b0;
      end
   end

   // output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else if (edge_sel == 2'b00) begin
         out_q <= 1'b0;
      end else begin
         unique case (fn)
            FN_COMPARE: begin
               if (match) begin
                  unique case (edge_sel)
                     2'b01:   out_q <= ~out_q;
                     2'b10:   out_q <= 1'b0;
                     default: out_q <= 1'b1;
                  endcase
               end
            end
            FN_EDGE_PWM, FN_CENTER_PWM: out_q <= (cnt_d < cval) ^ edge_sel[0];
            default:                    out_q <= 1'b0;
         endcase
      end
   end

   always_comb begin
      unique case (bus_sel)
         SEL_STAT:       bus_rdata = {flag, {(BW-1){1'b0}}};
         SEL_HI, SEL_LO: bus_rdata = val_rdata;
         default:        bus_rdata = '0;
      endcase
   end

   assign ch_out  = out_q;
   assign irq     = flag && irq_en;
   assign cnt_val = cnt_q;

endmodule

// File: rtl/cappwm_chan_chk.sv
module cappwm_chan_chk
   import cappwm_pkg::*;
#(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    fn,
   input logic [1:0]    edge_sel,
   input logic          irq_en,
   input logic          irq,
   input logic          flag,
   input logic          cap_evt,
   input logic          match,
   input logic          ch_out,
   input logic [CW-1:0] cnt_q,
   input logic [CW-1:0] cval
);

   logic cmp_tog, pwm_hi, pwm_lo;
   assign cmp_tog = (fn == FN_COMPARE) && (edge_sel == 2'b01) && match;
   assign pwm_hi  = ((fn == FN_EDGE_PWM) || (fn == FN_CENTER_PWM)) && (edge_sel == 2'b10);
   assign pwm_lo  = (fn == FN_CENTER_PWM) && edge_sel[0];

   // R12
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && flag));

   // R12
   cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> flag);

   // R10
   cap_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fn == FN_CAPTURE) && !cap_evt) |=> $stable(cval));

   // R8
   disc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel == 2'b00) |=> !ch_out);

   // R5
   cmp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_tog |=> (ch_out != $past(ch_out)));

   // R6
   pwm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_hi |=> (!$stable(cval) || (ch_out == (cnt_q < cval))));

   // R7
   cpwm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_lo |=> (!$stable(cval) || (ch_out == !(cnt_q < cval))));

endmodule

bind cappwm_chan cappwm_chan_chk #(.CW(CW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .fn       (fn),
   .edge_sel (edge_sel),
   .irq_en   (irq_en),
   .irq      (irq),
   .flag     (flag),
   .cap_evt  (cap_evt),
   .match    (match),
   .ch_out   (ch_out),
   .cnt_q    (cnt_q),
   .cval     (cval)
);

// File: tb/cappwm_chan_tb.sv
`timescale 1ns/1ps
module cappwm_chan_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] modulus = 16'hFFFF;
   logic        center_sel = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic [1:0]  edge_sel = 2'b00;
   logic        irq_en = 1'b0;
   logic        cap_pin = 1'b0;
   logic [1:0]  bus_sel = 2'b00;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        ch_out, irq;
   logic [15:0] cnt_val;

   int nchk  = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   cappwm_chan dut_i (
      .clk(clk), .rst_n(rst_n), .modulus(modulus), .center_sel(center_sel),
      .mode_sel(mode_sel), .edge_sel(edge_sel), .irq_en(irq_en), .cap_pin(cap_pin),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ch_out(ch_out), .irq(irq), .cnt_val(cnt_val)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      bus_sel = s; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd_val(output logic [15:0] v);
      logic [7:0] h, l;
      bus_read(2'd1, h);
      bus_read(2'd2, l);
      v = {h, l};
   endtask

   task automatic wr_val(input logic [15:0] v);
      bus_write(2'd1, v[15:8]);
      bus_write(2'd2, v[7:0]);
   endtask

   task automatic stat_touch();
      logic [7:0] d;
      bus_read(2'd0, d);
   endtask

   task automatic set_cfg(input logic c, input logic [1:0] m, input logic [1:0] e);
      @(negedge clk);
      center_sel = c; mode_sel = m; edge_sel = e;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive the pin, return the counter value seen in the detection cycle
   task automatic cap_edge(input logic v, output logic [15:0] c);
      @(negedge clk);
      cap_pin = v;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      c = cnt_val;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      logic [7:0] s;
      @(negedge clk);
      chk(cnt_val == 16'h0, "R1 counter in reset", cnt_val, 0);
      chk(ch_out == 1'b0, "R1 output in reset", ch_out, 0);
      chk(irq == 1'b0, "R1 irq in reset", irq, 0);
      rst_n = 1'b1;
      rd_val(v);
      chk(v == 16'h0, "R1 value after reset", v, 0);
      bus_read(2'd0, s);
      chk(s[7] == 1'b0, "R1 flag after reset", s[7], 0);
   endtask

   task automatic t_counter();
      int prev, exp;
      bit up;
      modulus = 16'd5;
      set_cfg(1'b0, 2'b10, 2'b00);
      idle(8);
      prev = cnt_val;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         exp = (prev >= 5) ? 0 : prev + 1;
         chk(cnt_val == exp, "R2 edge count", cnt_val, exp);
         prev = cnt_val;
      end
      @(negedge clk);
      center_sel = 1'b1;
      prev = cnt_val;
      up = 1'b1;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (up) begin
            if (prev >= 5) begin exp = 4; up = 1'b0; end
            else exp = prev + 1;
         end else begin
            if (prev == 0) begin exp = 1; up = 1'b1; end
            else exp = prev - 1;
         end
         chk(cnt_val == exp, "R2 center count", cnt_val, exp);
         prev = cnt_val;
      end
   endtask

   task automatic t_capture();
      logic [15:0] c, c2, v;
      logic [7:0] s;
      modulus = 16'hFFFF;
      irq_en = 1'b1;
      set_cfg(1'b0, 2'b00, 2'b01);
      idle(3);
      stat_touch();
      cap_edge(1'b1, c);
      rd_val(v);
      chk(v == c, "R4 rising capture value", v, c);
      bus_read(2'd0, s);
      chk(s[7] == 1'b1, "R12 flag after capture", s[7], 1);
      chk(irq == 1'b1, "R12 irq with enable", irq, 1);
      cap_edge(1'b0, c2);
      rd_val(v);
      chk(v == c, "R3 falling ignored for 01", v, c);
      set_cfg(1'b0, 2'b00, 2'b10);
      cap_edge(1'b1, c2);
      rd_val(v);
      chk(v == c, "R3 rising ignored for 10", v, c);
      cap_edge(1'b0, c);
      rd_val(v);
      chk(v == c, "R3 falling capture for 10", v, c);
      set_cfg(1'b0, 2'b00, 2'b11);
      cap_edge(1'b1, c);
      rd_val(v);
      chk(v == c, "R3 both: rising", v, c);
      cap_edge(1'b0, c);
      rd_val(v);
      chk(v == c, "R3 both: falling", v, c);
   endtask

   task automatic t_coherent();
      logic [15:0] a, b, c;
      logic [7:0] d;
      stat_touch();
      cap_edge(1'b1, a);
      bus_read(2'd1, d);
      chk(d == a[15:8], "R9 high byte", d, a[15:8]);
      cap_edge(1'b0, b);
      bus_read(2'd2, d);
      chk(d == a[7:0], "R9 low byte frozen", d, a[7:0]);
      bus_read(2'd1, d);
      chk(d == b[15:8], "R9 released high", d, b[15:8]);
      bus_read(2'd2, d);
      chk(d == b[7:0], "R9 released low", d, b[7:0]);
      bus_read(2'd1, d);
      cap_edge(1'b1, c);
      stat_touch();
      bus_read(2'd2, d);
      chk(d == c[7:0], "R11 status releases freeze", d, c[7:0]);
   endtask

   task automatic t_flag();
      logic [7:0] s;
      logic [15:0] v0, v, c;
      set_cfg(1'b0, 2'b00, 2'b00);
      rd_val(v0);
      cap_edge(1'b0, c);
      rd_val(v);
      chk(v == v0, "R8 no capture when disconnected", v, v0);
      bus_write(2'd0, 8'h80);
      bus_write(2'd0, 8'h00);
      bus_read(2'd0, s);
      chk(s[7] == 1'b1, "R12 zero write without read keeps flag", s[7], 1);
      bus_write(2'd0, 8'h00);
      bus_read(2'd0, s);
      chk(s[7] == 1'b0, "R12 flag cleared", s[7], 0);
      chk(irq == 1'b0, "R12 irq follows flag", irq, 0);
      cap_edge(1'b1, c);
      bus_read(2'd0, s);
      chk(s[7] == 1'b0, "R8 no flag when disconnected", s[7], 0);
   endtask

   task automatic t_write();
      logic [15:0] v0, v;
      modulus = 16'hFFFF;
      set_cfg(1'b0, 2'b01, 2'b00);
      stat_touch();
      rd_val(v0);
      bus_write(2'd1, 8'h12);
      rd_val(v);
      chk(v == v0, "R10 half write held", v, v0);
      bus_write(2'd2, 8'h34);
      rd_val(v);
      chk(v == 16'h1234, "R10 pair committed", v, 16'h1234);
      bus_write(2'd1, 8'h56);
      stat_touch();
      bus_write(2'd2, 8'h78);
      rd_val(v);
      chk(v == 16'h1234, "R11 status drops half write", v, 16'h1234);
      bus_write(2'd1, 8'h9A);
      rd_val(v);
      chk(v == 16'h9A78, "R10 new pair after drop", v, 16'h9A78);
      set_cfg(1'b0, 2'b00, 2'b00);
      wr_val(16'hBEEF);
      rd_val(v);
      chk(v == 16'h9A78, "R10 capture mode ignores writes", v, 16'h9A78);
   endtask

   task automatic wait_match(input logic [15:0] val, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 400 && !seen; i++) begin
         @(negedge clk);
         if (cnt_val == val) seen = 1'b1;
      end
   endtask

   task automatic t_compare();
      bit seen;
      logic o;
      logic [7:0] s;
      modulus = 16'd99;
      set_cfg(1'b0, 2'b01, 2'b01);
      wr_val(16'd40);
      wait_match(16'd40, seen);
      o = ch_out;
      @(negedge clk);
      chk(seen && ch_out == !o, "R5 toggle on match", ch_out, !o);
      bus_read(2'd0, s);
      chk(s[7] == 1'b1, "R12 flag on compare match", s[7], 1);
      set_cfg(1'b0, 2'b01, 2'b11);
      wait_match(16'd40, seen);
      @(negedge clk);
      chk(seen && ch_out == 1'b1, "R5 set on match", ch_out, 1);
      set_cfg(1'b0, 2'b01, 2'b10);
      wait_match(16'd40, seen);
      @(negedge clk);
      chk(seen && ch_out == 1'b0, "R5 clear on match", ch_out, 0);
   endtask

   task automatic pwm_scan(input int n, input int val, input bit inv, input string req);
      bit ok = 1'b1;
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (ch_out != ((cnt_val < val) ^ inv)) begin ok = 1'b0; bad = cnt_val; end
      end
      chk(ok, req, bad, val);
   endtask

   task automatic t_epwm();
      modulus = 16'd9;
      set_cfg(1'b0, 2'b10, 2'b10);
      wr_val(16'd4);
      idle(3);
      pwm_scan(20, 4, 1'b0, "R6 high-true edge PWM");
      set_cfg(1'b0, 2'b11, 2'b01);
      idle(2);
      pwm_scan(20, 4, 1'b1, "R6 low-true edge PWM (01)");
      set_cfg(1'b0, 2'b10, 2'b11);
      idle(2);
      pwm_scan(20, 4, 1'b1, "R6 low-true edge PWM (11)");
      set_cfg(1'b0, 2'b10, 2'b10);
      wr_val(16'd0);
      idle(3);
      pwm_scan(20, 0, 1'b0, "R6 zero duty");
      wr_val(16'd10);
      idle(3);
      pwm_scan(20, 10, 1'b0, "R6 full duty");
   endtask

   task automatic t_cpwm();
      bit down = 1'b0;
      int prev;
      modulus = 16'd9;
      set_cfg(1'b1, 2'b00, 2'b10);
      wr_val(16'd4);
      idle(3);
      prev = cnt_val;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (cnt_val < prev) down = 1'b1;
         prev = cnt_val;
      end
      chk(down, "R7 counter reverses with mode bits 00", down, 1);
      pwm_scan(40, 4, 1'b0, "R7 high-true center PWM");
      set_cfg(1'b1, 2'b01, 2'b01);
      idle(2);
      pwm_scan(40, 4, 1'b1, "R7 low-true center PWM");
   endtask

   task automatic t_disc();
      bit ok = 1'b1;
      modulus = 16'd9;
      set_cfg(1'b0, 2'b10, 2'b00);
      idle(2);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ch_out) ok = 1'b0;
      end
      chk(ok, "R8 output low when disconnected", ch_out, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_counter();
      t_capture();
      t_coherent();
      t_flag();
      t_write();
      t_compare();
      t_epwm();
      t_cpwm();
      t_disc();
      idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(20 * 100000);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule